// File: doc/BRIEF.md
# Serial Word Copy Between Shift Registers

This block holds two shift registers of the same width, a source and a destination. On request it copies the source word into the destination one bit per clock. Both registers shift right together. The bit that leaves the source at its right end enters the destination at the left end. The same bit is also fed back into the source's own left end, so the source rotates and keeps its value. The destination's old contents fall off its right end and are discarded.

A small controller raises a synchronous shift enable on the free-running clock. It keeps the enable high for exactly one word length of cycles, then stops both registers and gives a one-cycle completion pulse. Parallel preload and parallel read-back ports let a test or a host set and observe both registers. An active-low asynchronous clear zeroes every flip-flop.

Top module: `sercopy_unit`

## Requirements
- R1: While `clr_n` is 0, both registers, `busy_o` and `done_o` are 0 at once, without waiting for a clock edge. This also applies in the middle of a transfer.
- R2: A `start_i` sampled high while idle, with neither load input high, makes `busy_o` 1 from the next cycle. `busy_o` then stays 1 for exactly WIDTH cycles.
- R3: When a transfer ends, the destination equals the source's value from before the transfer, and the source holds that same value again.
- R4: On each enabled cycle both registers shift right by one. Bit 0 of the source enters bit WIDTH-1 of both the source and the destination, and bit 0 of the destination is discarded.
- R5: `done_o` is 1 for exactly one cycle. That cycle is the one after the final shift, and `busy_o` is 0 in it.
- R6: A `start_i` received while `busy_o` is 1 is ignored. The transfer still lasts WIDTH cycles and no second transfer follows.
- R7: Load requests received while `busy_o` is 1 are ignored, so the copy result is unaffected.
- R8: When `start_i` and a load input are high in the same idle cycle, the load is performed and no transfer starts.
- R9: While idle with no load input high, both registers keep their values.
- R10: While idle, `src_load_i` writes `src_val_i` into the source and `dst_load_i` writes `dst_val_i` into the destination. Each load acts on its own register only, in one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| start_i | input | 1 | Request to copy source into destination |
| src_load_i | input | 1 | Parallel load of the source register |
| src_val_i | input | WIDTH | Value for the source preload |
| dst_load_i | input | 1 | Parallel load of the destination register |
| dst_val_i | input | WIDTH | Value for the destination preload |
| src_q_o | output | WIDTH | Source register contents |
| dst_q_o | output | WIDTH | Destination register contents |
| busy_o | output | 1 | High while shifting is enabled |
| done_o | output | 1 | One-cycle pulse after the final shift |

## Verification
The assertions check these rules on every cycle:
- each enabled cycle moves source bit 0 into the top bit of both registers;
- an idle register with no load holds still;
- the bit counter stays within range;
- a start or a load arriving while busy changes nothing;
- a load blocks a start in the same cycle;
- `done_o` follows the final shift.

Only the bench scenarios can show that a complete run of WIDTH shifts copies the whole word and restores the source. They run this for every pair of 4-bit preload values. They also show that a clear partway through a transfer leaves everything at zero.

// File: rtl/sercopy_pkg.sv
package sercopy_pkg;

  // Per-cycle action taken by a shift register.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } reg_op_e;

endpackage

// File: rtl/sercopy_shreg.sv
module sercopy_shreg
  import sercopy_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  reg_op_e          op,
  input  logic [WIDTH-1:0] load_val,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q,
  output logic             ser_out
);

  // The new bit enters at the left end and every bit moves one place right.
  function automatic logic [WIDTH-1:0] enter_left(input logic [WIDTH-1:0] v, input logic b);
    return {b, v[WIDTH-1:1]};
  endfunction

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD:  q <= load_val;
        OP_SHIFT: q <= enter_left(q, ser_in);
        default:  q <= q;
      endcase
    end
  end

  assign ser_out = q[0];

  // R9: a register with no operation keeps its value
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!clr_n)
    op == OP_HOLD |=> $stable(q));

  // R4: a shift puts the serial input at the top bit
  a_r4_shift_top: assert property (@(posedge clk) disable iff (!clr_n)
    op == OP_SHIFT |=> q[WIDTH-1] == $past(ser_in));

endmodule

// File: rtl/sercopy_ctrl.sv
module sercopy_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic clr_n,
  input  logic start,
  input  logic any_load,
  output logic busy,
  output logic done,
  output logic shift_en,
  output logic last_shift,
  output logic start_accept
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] cnt;

  assign start_accept = start && !busy && !any_load;
  assign shift_en     = busy;
  assign last_shift   = busy && (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_shift;
      if (start_accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (last_shift) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: an accepted start opens a window at shift index zero
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!clr_n)
    start_accept |=> busy && cnt == '0);

  // R2: the shift counter never passes the last bit index
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!clr_n)
    busy |-> cnt <= LAST_IDX);

  // R5: the final shift is followed by done with busy low
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!clr_n)
    last_shift |=> done && !busy);

  // R5: done never lasts two cycles
  a_r5_done_single: assert property (@(posedge clk) disable iff (!clr_n)
    done |=> !done);

  // R6: a transfer in progress runs on whatever start does
  a_r6_busy_continues: assert property (@(posedge clk) disable iff (!clr_n)
    busy && !last_shift |=> busy && cnt == $past(cnt) + 1'b1);

  // R8: a load in an idle cycle blocks a start
  a_r8_load_blocks_start: assert property (@(posedge clk) disable iff (!clr_n)
    !busy && any_load |=> !busy);

endmodule

// File: rtl/sercopy_unit.sv
module sercopy_unit
  import sercopy_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             start_i,
  input  logic             src_load_i,
  input  logic [WIDTH-1:0] src_val_i,
  input  logic             dst_load_i,
  input  logic [WIDTH-1:0] dst_val_i,
  output logic [WIDTH-1:0] src_q_o,
  output logic [WIDTH-1:0] dst_q_o,
  output logic             busy_o,
  output logic             done_o
);

  logic    shift_en;
  logic    last_shift;
  logic    start_accept;
  logic    any_load;
  logic    link_bit;
  logic    dst_drop;
  reg_op_e src_op;
  reg_op_e dst_op;

  assign any_load = src_load_i || dst_load_i;

  sercopy_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk          (clk),
    .clr_n        (clr_n),
    .start        (start_i),
    .any_load     (any_load),
    .busy         (busy_o),
    .done         (done_o),
    .shift_en     (shift_en),
    .last_shift   (last_shift),
    .start_accept (start_accept)
  );

  // Shifting wins. Loads are honoured only while idle.
  always_comb begin
    if (shift_en)        src_op = OP_SHIFT;
    else if (src_load_i) src_op = OP_LOAD;
    else                 src_op = OP_HOLD;
    if (shift_en)        dst_op = OP_SHIFT;
    else if (dst_load_i) dst_op = OP_LOAD;
    else                 dst_op = OP_HOLD;
  end

  // The source's serial output feeds its own input and the destination's input.
  sercopy_shreg #(.WIDTH(WIDTH)) u_src (
    .clk      (clk),
    .clr_n    (clr_n),
    .op       (src_op),
    .load_val (src_val_i),
    .ser_in   (link_bit),
    .q        (src_q_o),
    .ser_out  (link_bit)
  );

  sercopy_shreg #(.WIDTH(WIDTH)) u_dst (
    .clk      (clk),
    .clr_n    (clr_n),
    .op       (dst_op),
    .load_val (dst_val_i),
    .ser_in   (link_bit),
    .q        (dst_q_o),
    .ser_out  (dst_drop)
  );

  // R4: both registers take the same bit that left the source
  a_r4_dst_gets_src_bit: assert property (@(posedge clk) disable iff (!clr_n)
    shift_en |=> dst_q_o[WIDTH-1] == $past(src_q_o[0]) &&
                 dst_q_o[WIDTH-2:0] == $past(dst_q_o[WIDTH-1:1]));

  // R7: a source load during a transfer does not disturb the rotation
  a_r7_load_ignored_busy: assert property (@(posedge clk) disable iff (!clr_n)
    busy_o && src_load_i |=> src_q_o == {$past(src_q_o[0]), $past(src_q_o[WIDTH-1:1])});

  // R10: an idle load writes the value presented
  a_r10_src_load: assert property (@(posedge clk) disable iff (!clr_n)
    !busy_o && src_load_i |=> src_q_o == $past(src_val_i));

endmodule

// File: tb/sercopy_unit_bench.sv
module sercopy_unit_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         start_i = 1'b0;
  logic         src_load_i = 1'b0;
  logic [W-1:0] src_val_i = '0;
  logic         dst_load_i = 1'b0;
  logic [W-1:0] dst_val_i = '0;
  logic [W-1:0] src_q_o;
  logic [W-1:0] dst_q_o;
  logic         busy_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sercopy_unit #(.WIDTH(W)) u_sercopy_unit (
    .clk        (clk),
    .clr_n      (clr_n),
    .start_i    (start_i),
    .src_load_i (src_load_i),
    .src_val_i  (src_val_i),
    .dst_load_i (dst_load_i),
    .dst_val_i  (dst_val_i),
    .src_q_o    (src_q_o),
    .dst_q_o    (dst_q_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Bench model of one shift: the low bit of the source goes to the top of both registers.
  function automatic logic [W-1:0] model_step(input logic [W-1:0] v, input logic top);
    logic [W-1:0] r;
    for (int i = 0; i < W - 1; i++) r[i] = v[i+1];
    r[W-1] = top;
    return r;
  endfunction

  task automatic t_reset();
    clr_n = 1'b0;
    #1;
    check("R1 src after clear", src_q_o, 0);
    check("R1 dst after clear", dst_q_o, 0);
    check("R1 busy after clear", busy_o, 0);
    check("R1 done after clear", done_o, 0);
    @(negedge clk);
    clr_n = 1'b1;
    tick();
  endtask

  task automatic t_load(input logic [W-1:0] a, input logic [W-1:0] b);
    src_load_i = 1'b1; src_val_i = a;
    dst_load_i = 1'b1; dst_val_i = b;
    tick();
    src_load_i = 1'b0; dst_load_i = 1'b0;
    check("R10 src load", src_q_o, a);
    check("R10 dst load", dst_q_o, b);
  endtask

  // Full transfer. When a value is given, a start is issued again while busy (R6).
  // Loads may also be presented while busy (R7).
  task automatic t_copy(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit restart_mid, input bit load_mid);
    logic [W-1:0] es, ed;
    logic bit0;
    t_load(a, b);
    es = a; ed = b;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check("R2 busy after start", busy_o, 1);
    check("R9 no shift yet", src_q_o, a);
    for (int i = 0; i < W; i++) begin
      if (i == 1 && restart_mid) start_i = 1'b1;
      if (i == 1 && load_mid) begin
        src_load_i = 1'b1; src_val_i = ~a;
        dst_load_i = 1'b1; dst_val_i = ~b;
      end
      tick();
      start_i = 1'b0; src_load_i = 1'b0; dst_load_i = 1'b0;
      bit0 = es[0];
      es = model_step(es, bit0);
      ed = model_step(ed, bit0);
      check("R4 src per shift", src_q_o, es);
      check("R4 dst per shift", dst_q_o, ed);
      if (i < W - 1) begin
        check("R2 busy held", busy_o, 1);
        check("R5 no early done", done_o, 0);
      end else begin
        check("R2 busy drops after W", busy_o, 0);
        check("R5 done after last shift", done_o, 1);
      end
    end
    tick();
    check("R5 done one cycle", done_o, 0);
    check("R6 no second transfer", busy_o, 0);
    check("R3 dst equals original src", dst_q_o, a);
    check("R3 src restored", src_q_o, a);
    tick();
    check("R9 idle hold src", src_q_o, a);
    check("R9 idle hold dst", dst_q_o, a);
  endtask

  task automatic t_priority();
    t_load(4'b0110, 4'b1001);
    start_i = 1'b1;
    src_load_i = 1'b1; src_val_i = 4'b1100;
    tick();
    start_i = 1'b0; src_load_i = 1'b0;
    check("R8 load taken", src_q_o, 4'b1100);
    check("R8 no start", busy_o, 0);
    check("R10 dst untouched by src load", dst_q_o, 4'b1001);
    tick();
    check("R8 still idle", busy_o, 0);
    check("R8 dst unchanged", dst_q_o, 4'b1001);
  endtask

  task automatic t_clear_mid();
    t_load(4'b1011, 4'b0010);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    tick();
    clr_n = 1'b0;
    #1;
    check("R1 clear mid src", src_q_o, 0);
    check("R1 clear mid dst", dst_q_o, 0);
    check("R1 clear mid busy", busy_o, 0);
    tick();
    clr_n = 1'b1;
    tick();
    check("R1 stays idle after clear", busy_o, 0);
    check("R1 done low after clear", done_o, 0);
  endtask

  initial begin
    t_reset();
    t_copy(4'b1011, 4'b0010, 0, 0);
    t_copy(4'b0101, 4'b1111, 1, 0);
    t_copy(4'b1000, 4'b0111, 0, 1);
    t_priority();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        t_copy(4'(a), 4'(b), 0, 0);
    t_clear_mid();
    finished = 1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule